// File: doc/BRIEF.md
# Timer Status Flag and Freeze Control Unit

This block holds the status flags of a multi-channel capture/compare timer. The timer core sends single-cycle event strobes: one per channel, one for counter overflow, and three for the pulse accumulators. These are a first-accumulator overflow, a first-accumulator input edge and a second-accumulator overflow. Each strobe sets a sticky flag. Software reaches the flags, a small control register and a bank of per-channel toggle-on-overflow bits through a simple register bus. The bus has an address, a read strobe, a write strobe and write data.

Software can clear flags in two ways. The first is a write-one-to-clear to the flag registers, which works in every mode. The second is fast-clear mode, selected by a control bit. In that mode a flag also clears as a side effect of touching the data register it belongs to. For a capture channel that is a read, and for a compare channel it is a write. For the counter and the accumulator count registers it is any access. The block does not store the data registers themselves: it only decodes accesses to their addresses.

A second control bit, the freeze-stop bit, lets a debug freeze input halt the main and modulus counters through a hold output. The pulse accumulators are not affected by freeze, so their flags keep setting.

Top module: `tmr_flag_unit`

## Requirements
- R1: After synchronous reset, all channel flags, all misc flags, the control bits and the toggle-on-overflow bits are zero. Reads of addresses 0x00 (control) and 0x03 (toggle bits) return zero.
- R2: A strobe on `ch_evt[n]` or `misc_evt[k]` sets the corresponding flag on the next clock edge. The flag then stays set until it is cleared. Channel flags read back at address 0x01. Misc flags read back at 0x02, with bit 0 as counter overflow, bit 1 as accumulator A overflow, bit 2 as accumulator A edge and bit 3 as accumulator B overflow.
- R3: In either mode, a write to 0x01 or 0x02 clears each flag whose write-data bit is one. Flags whose write-data bit is zero are left unchanged.
- R4: With fast-clear on (control bit 0), a read of channel data address 0x10+n clears channel flag n when `ch_is_oc[n]` is 0 (input capture). A write to that address does not clear it.
- R5: With fast-clear on, a write to channel data address 0x10+n clears channel flag n when `ch_is_oc[n]` is 1 (output compare). A read of that address does not clear it.
- R6: With fast-clear on, a read or a write of counter address 0x04 clears the counter overflow flag (misc bit 0) and no other flag.
- R7: With fast-clear on, any access to 0x05 clears misc bits 1 and 2. Any access to 0x06 clears misc bit 3.
- R8: With fast-clear off, accesses to 0x04, 0x05, 0x06 and 0x10+n clear no flag.
- R9: When a set strobe and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R10: `cnt_hold` is high exactly when the freeze-stop bit (control bit 1) and `freeze` are both high. Misc flags still set from their strobes while `cnt_hold` is high.
- R11: The toggle-on-overflow bits are written at address 0x03 at any time. They read back there and appear on `tov`. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_evt | input | N_CH | Per-channel event strobes from the timer core |
| misc_evt | input | 4 | Overflow and accumulator event strobes |
| ch_is_oc | input | N_CH | Per-channel mode: 1 output compare, 0 input capture |
| freeze | input | 1 | Debug freeze request |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| ch_flags | output | N_CH | Channel event flags |
| misc_flags | output | 4 | Counter overflow and accumulator flags |
| tov | output | N_CH | Toggle-on-overflow control bits |
| cnt_hold | output | 1 | Hold request for main and modulus counters |

## Verification
The bench builds the block with the default of eight channels. Channels 0 to 3 are set to input capture and channels 4 to 7 to output compare. This lets one run exercise the read-clears and write-clears paths, and also show that the opposite access leaves a flag alone. The full eight-bit channel width means a write-one-to-clear with all ones, or with a mixed pattern, covers every flag bit of the register.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int N_MISC = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_CHFLG = 5'h01;
    localparam logic [ADDR_W-1:0] A_MISC  = 5'h02;
    localparam logic [ADDR_W-1:0] A_TOV   = 5'h03;
    localparam logic [ADDR_W-1:0] A_CNT   = 5'h04;
    localparam logic [ADDR_W-1:0] A_PAHI  = 5'h05;
    localparam logic [ADDR_W-1:0] A_PALO  = 5'h06;
    localparam logic [ADDR_W-1:0] A_CH0   = 5'h10;

    localparam int M_OVF     = 0;
    localparam int M_PA_OVF  = 1;
    localparam int M_PA_EDGE = 2;
    localparam int M_PB_OVF  = 3;

    typedef struct packed {
        logic frz_stop;
        logic fast_clr;
    } ctrl_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_t;

    function automatic logic touches(bus_t b, logic [ADDR_W-1:0] a);
        return (b.rd || b.wr) && (b.addr == a);
    endfunction
endpackage

// File: rtl/tfu_flag_bank.sv
module tfu_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R9: a set in the same cycle as a clear still leaves the flag set
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);
        // R3: a clear with no set drops the flag
        p_clear_r3: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !q[i]);
        // R2: with neither set nor clear, the flag holds its value
        p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
            (!set[i] && !clr[i]) |=> $stable(q[i]));
    end
endmodule

// File: rtl/tfu_ctrl_regs.sv
module tfu_ctrl_regs
    import tfu_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_t            bus,
    output ctrl_t           ctrl,
    output logic [N_CH-1:0] tov
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            tov  <= '0;
        end else if (bus.wr) begin
            if (bus.addr == A_CTRL) begin
                ctrl.fast_clr <= bus.wdata[0];
                ctrl.frz_stop <= bus.wdata[1];
            end
            if (bus.addr == A_TOV) tov <= bus.wdata[N_CH-1:0];
        end
    end

    // R11: toggle bits take the written value on the next edge
    p_tov_write_r11: assert property (@(posedge clk) disable iff (rst)
        (bus.wr && bus.addr == A_TOV) |=> tov == $past(bus.wdata[N_CH-1:0]));
    // R11: toggle bits are untouched without a write to their address
    p_tov_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus.wr && bus.addr == A_TOV) |=> $stable(tov));
endmodule

// File: rtl/tfu_clr_decode.sv
module tfu_clr_decode
    import tfu_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_t              bus,
    input  ctrl_t             ctrl,
    input  logic [N_CH-1:0]   ch_is_oc,
    output logic [N_CH-1:0]   clr_ch,
    output logic [N_MISC-1:0] clr_misc
);
    logic [N_CH-1:0]   fast_ch;
    logic [N_MISC-1:0] fast_misc;
    logic              w1c_ch;
    logic              w1c_misc;

    assign w1c_ch   = bus.wr && (bus.addr == A_CHFLG);
    assign w1c_misc = bus.wr && (bus.addr == A_MISC);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = A_CH0 + ADDR_W'(i);
        logic hit;
        assign hit        = bus.addr == CH_ADDR;
        assign fast_ch[i] = ctrl.fast_clr && hit && (ch_is_oc[i] ? bus.wr : bus.rd);
        assign clr_ch[i]  = (w1c_ch && bus.wdata[i]) || fast_ch[i];
    end

    always_comb begin
        fast_misc            = '0;
        fast_misc[M_OVF]     = touches(bus, A_CNT);
        fast_misc[M_PA_OVF]  = touches(bus, A_PAHI);
        fast_misc[M_PA_EDGE] = touches(bus, A_PAHI);
        fast_misc[M_PB_OVF]  = touches(bus, A_PALO);
        if (!ctrl.fast_clr) fast_misc = '0;
        clr_misc = fast_misc | (w1c_misc ? bus.wdata[N_MISC-1:0] : '0);
    end

    // R8: with fast-clear off, only writes to the flag registers clear anything
    p_slow_ch_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.fast_clr && !w1c_ch) |-> clr_ch == '0);
    p_slow_misc_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.fast_clr && !w1c_misc) |-> clr_misc == '0);
    // R6: a counter access never clears accumulator flags
    p_cnt_only_r6: assert property (@(posedge clk) disable iff (rst)
        (bus.addr == A_CNT) |-> clr_misc[N_MISC-1:1] == '0);
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
    import tfu_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CH-1:0]      ch_evt,
    input  logic [N_MISC-1:0]    misc_evt,
    input  logic [N_CH-1:0]      ch_is_oc,
    input  logic                 freeze,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [N_CH-1:0]      ch_flags,
    output logic [N_MISC-1:0]    misc_flags,
    output logic [N_CH-1:0]      tov,
    output logic                 cnt_hold
);
    localparam int PAD_CH   = DATA_W - N_CH;
    localparam int PAD_MISC = DATA_W - N_MISC;

    bus_t              bus;
    ctrl_t             ctrl;
    logic [N_CH-1:0]   clr_ch;
    logic [N_MISC-1:0] clr_misc;

    assign bus = '{rd: bus_rd, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    tfu_ctrl_regs #(.N_CH(N_CH)) u_ctrl (
        .clk(clk), .rst(rst), .bus(bus), .ctrl(ctrl), .tov(tov)
    );

    tfu_clr_decode #(.N_CH(N_CH)) u_dec (
        .clk(clk), .rst(rst), .bus(bus), .ctrl(ctrl), .ch_is_oc(ch_is_oc),
        .clr_ch(clr_ch), .clr_misc(clr_misc)
    );

    tfu_flag_bank #(.W(N_CH)) u_chflags (
        .clk(clk), .rst(rst), .set(ch_evt), .clr(clr_ch), .q(ch_flags)
    );

    tfu_flag_bank #(.W(N_MISC)) u_miscflags (
        .clk(clk), .rst(rst), .set(misc_evt), .clr(clr_misc), .q(misc_flags)
    );

    assign cnt_hold = ctrl.frz_stop && freeze;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {{(DATA_W-2){1'b0}}, ctrl.frz_stop, ctrl.fast_clr};
            A_CHFLG: bus_rdata = {{PAD_CH{1'b0}}, ch_flags};
            A_MISC:  bus_rdata = {{PAD_MISC{1'b0}}, misc_flags};
            A_TOV:   bus_rdata = {{PAD_CH{1'b0}}, tov};
            default: bus_rdata = '0;
        endcase
    end

    // R10: the counters are only held while freeze is requested
    p_hold_needs_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        !freeze |-> !cnt_hold);
endmodule

// File: tb/tmr_flag_unit_test.sv
`timescale 1ns/1ps
module tmr_flag_unit_test;
    import tfu_pkg::*;

    localparam int N_CH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_CH-1:0] ch_evt = '0;
    logic [3:0] misc_evt = '0;
    logic [N_CH-1:0] ch_is_oc = 8'hF0;
    logic freeze = 1'b0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [N_CH-1:0] ch_flags, tov;
    logic [3:0] misc_flags;
    logic cnt_hold;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    tmr_flag_unit #(.N_CH(N_CH)) uut (
        .clk(clk), .rst(rst), .ch_evt(ch_evt), .misc_evt(misc_evt),
        .ch_is_oc(ch_is_oc), .freeze(freeze), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_flags(ch_flags), .misc_flags(misc_flags), .tov(tov), .cnt_hold(cnt_hold)
    );

    typedef struct packed {
        logic [7:0] ce;
        logic [3:0] me;
        logic       rd;
        logic       wr;
        logic [4:0] a;
        logic [7:0] wd;
        logic [7:0] xc;
        logic [3:0] xm;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        '{8'hFF, 4'hF, 1'b0, 1'b0, 5'h00, 8'h00, 8'hFF, 4'hF, 4'd2},  // R2 all events
        '{8'h00, 4'h0, 1'b1, 1'b0, 5'h10, 8'h00, 8'hFF, 4'hF, 4'd8},  // R8 read IC ch0, slow
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h14, 8'h00, 8'hFF, 4'hF, 4'd8},  // R8 write OC ch4, slow
        '{8'h00, 4'h0, 1'b1, 1'b0, 5'h04, 8'h00, 8'hFF, 4'hF, 4'd8},  // R8 counter read, slow
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h06, 8'h00, 8'hFF, 4'hF, 4'd8},  // R8 acc B write, slow
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h01, 8'h03, 8'hFC, 4'hF, 4'd3},  // R3 w1c mixed
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h02, 8'h00, 8'hFC, 4'hF, 4'd3},  // R3 zeros keep
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h00, 8'h01, 8'hFC, 4'hF, 4'd4},  // R4 fast on
        '{8'h00, 4'h0, 1'b1, 1'b0, 5'h12, 8'h00, 8'hF8, 4'hF, 4'd4},  // R4 read IC ch2
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h13, 8'h00, 8'hF8, 4'hF, 4'd4},  // R4 write IC ch3 no clear
        '{8'h00, 4'h0, 1'b1, 1'b0, 5'h14, 8'h00, 8'hF8, 4'hF, 4'd5},  // R5 read OC ch4 no clear
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h14, 8'h00, 8'hE8, 4'hF, 4'd5},  // R5 write OC ch4
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h04, 8'h00, 8'hE8, 4'hE, 4'd6},  // R6 counter write
        '{8'h00, 4'h1, 1'b1, 1'b0, 5'h04, 8'h00, 8'hE8, 4'hF, 4'd9},  // R9 set wins
        '{8'h00, 4'h0, 1'b1, 1'b0, 5'h04, 8'h00, 8'hE8, 4'hE, 4'd6},  // R6 counter read
        '{8'h00, 4'h0, 1'b1, 1'b0, 5'h05, 8'h00, 8'hE8, 4'h8, 4'd7},  // R7 acc A pair
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h06, 8'h00, 8'hE8, 4'h0, 4'd7},  // R7 acc B pair
        '{8'h10, 4'h0, 1'b0, 1'b1, 5'h14, 8'h00, 8'hF8, 4'h0, 4'd9},  // R9 channel set wins
        '{8'h00, 4'h0, 1'b0, 1'b1, 5'h01, 8'hFF, 8'h00, 4'h0, 4'd3}   // R3 w1c in fast mode
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        ch_evt = '0; misc_evt = '0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cycle();
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic do_reset();
        rst = 1;
        idle_bus();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 ch_flags", ch_flags, 8'h00);
        check("R1 misc_flags", {4'h0, misc_flags}, 8'h00);
        check("R1 tov", tov, 8'h00);
        peek(A_CTRL, rd);
        check("R1 ctrl read", rd, 8'h00);
        peek(A_TOV, rd);
        check("R1 tov read", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            ch_evt = VT[i].ce; misc_evt = VT[i].me;
            bus_rd = VT[i].rd; bus_wr = VT[i].wr;
            bus_addr = VT[i].a; bus_wdata = VT[i].wd;
            cycle();
            check($sformatf("R%0d vec%0d ch", VT[i].req, i), ch_flags, VT[i].xc);
            check($sformatf("R%0d vec%0d misc", VT[i].req, i), {4'h0, misc_flags}, {4'h0, VT[i].xm});
        end

        // R2 flags read back through the bus
        ch_evt = 8'h5A; misc_evt = 4'h6;
        cycle();
        peek(A_CHFLG, rd);
        check("R2 chflg read", rd, 8'h5A);
        peek(A_MISC, rd);
        check("R2 misc read", rd, 8'h06);
        peek(A_CTRL, rd);
        check("R4 ctrl read fast", rd, 8'h01);

        // R11 toggle bits
        wr_reg(A_TOV, 8'hA5);
        check("R11 tov out", tov, 8'hA5);
        peek(A_TOV, rd);
        check("R11 tov read", rd, 8'hA5);
        peek(5'h1F, rd);
        check("R11 unmapped read", rd, 8'h00);

        // R10 freeze control
        wr_reg(A_MISC, 8'h0F);
        wr_reg(A_CTRL, 8'h02);
        freeze = 1;
        #1 check("R10 hold on", {7'h0, cnt_hold}, 8'h01);
        misc_evt = 4'hF;
        cycle();
        check("R10 acc flags in freeze", {4'h0, misc_flags}, 8'h0F);
        freeze = 0;
        #1 check("R10 hold off no freeze", {7'h0, cnt_hold}, 8'h00);
        wr_reg(A_CTRL, 8'h00);
        freeze = 1;
        #1 check("R10 hold off no stop", {7'h0, cnt_hold}, 8'h00);
        freeze = 0;

        // R1 reset clears everything set above
        do_reset();
        check("R1 re-reset ch", ch_flags, 8'h00);
        check("R1 re-reset misc", {4'h0, misc_flags}, 8'h00);
        check("R1 re-reset tov", tov, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule